// File: doc/BRIEF.md
# Pseudo-Channel Command Timing Guard

This block sits between a memory controller's command queue and one stacked-DRAM channel that is divided into two pseudo channels. The two pseudo channels share one command bus, but each executes its commands on its own. Every command carries a select bit that steers it to one pseudo channel. The guard keeps separate array timers and a separate open-bank map for each pseudo channel. It checks each presented command against that state and raises a same-cycle grant only when no timing rule would be broken. A command that is not granted is simply held, and the queue presents it again.

The guard has two command interfaces. The row interface takes activate, precharge, power-down entry and exit, self-refresh entry and exit, mode-register set and a no-op. The column interface takes reads and writes. The two interfaces are judged independently. Commands that act on the whole channel are granted only when both pseudo channels are quiet. The power state and the mode register are held once and shared by both pseudo channels. Each column access moves an 8-beat burst on the lane group that belongs to its pseudo channel, and that lane group is busy for 8/BEATS_PER_CLK cycles.

Top module: `pc_cmd_guard`

## Requirements
- R1: After reset, `pwr_state` is 0 (active), every bank of both pseudo channels is closed, `lane_busy` is 0, `mode_reg` is 0 and all timers are expired.
- R2: `row_pc`/`col_pc` select pseudo channel 0 (value 0) or 1 (value 1). An activate to one pseudo channel may be granted in the cycle right after an activate to the other.
- R3: An activate (`row_op`=0) is granted only to a closed bank, at least T_RRD cycles after the previous activate and at least T_RP cycles after the last precharge of the same pseudo channel.
- R4: A precharge (`row_op`=1) is granted only to an open bank, and it closes that bank.
- R5: A read or write is granted only to an open bank of its pseudo channel, and only at least T_RCD cycles after that pseudo channel's last activate.
- R6: A granted column access holds `lane_busy[pc]` (bit 0 = lane group 0 = pseudo channel 0) high for the following 8/BEATS_PER_CLK-1 cycles. No further column access to that pseudo channel is granted until the flag has cleared.
- R7: Power-down entry (`row_op`=2) and self-refresh entry (`row_op`=4) are granted only when every timer of both pseudo channels has expired and both lane groups are idle. Self-refresh entry also needs every bank closed. They set `pwr_state` to 1 and 2 respectively.
- R8: While `pwr_state` is 1 or 2, the only command granted is the matching exit: power-down exit (`row_op`=3) from state 1, self-refresh exit (`row_op`=5) from state 2. An exit returns `pwr_state` to 0.
- R9: After an exit is granted, no row or column command is granted for T_XP cycles.
- R10: Mode-register set (`row_op`=6) is granted only when the channel is active, all banks of both pseudo channels are closed and both precharge timers have expired. On grant, `row_arg` is loaded into the shared `mode_reg`.
- R11: A row command and a column command in the same cycle are judged independently, so both may be granted together.
- R12: `row_op`=7 (no-op) is never granted and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_valid | input | 1 | Row command present |
| row_op | input | 3 | Row command code (see R3–R12) |
| row_pc | input | 1 | Pseudo channel of the row command |
| row_bank | input | BW | Bank of an activate or precharge |
| row_arg | input | MRW | Value for mode-register set |
| row_grant | output | 1 | Row command accepted this cycle |
| col_valid | input | 1 | Column command present |
| col_wr | input | 1 | 1 = write, 0 = read |
| col_pc | input | 1 | Pseudo channel of the column command |
| col_bank | input | BW | Bank of the column command |
| col_grant | output | 1 | Column command accepted this cycle |
| lane_busy | output | 2 | Burst in flight per lane group |
| pwr_state | output | 2 | 0 active, 1 powered down, 2 self-refresh |
| mode_reg | output | MRW | Shared mode-register value |

## Verification
The bench builds the guard with T_RRD=3, T_RCD=4, T_RP=5, T_XP=6, four banks per pseudo channel and two beats per clock, which gives a four-cycle burst. Because each timer has a different value, an error that swaps two timers, mixes up the two pseudo channels or is off by one in a count leads to a grant in the wrong cycle. With only four banks, biased random traffic often finds every bank of a pseudo channel open or closed. That reaches the rules that depend on all banks being closed (self-refresh entry and mode-register set) as well as the refusal of an activate to an open bank. Power entries and exits are frequent enough that the exit delay is seen many times.

// File: rtl/pc_cmd_guard.sv
module pc_cmd_guard #(
  parameter int T_RRD = 4,
  parameter int T_RCD = 6,
  parameter int T_RP = 6,
  parameter int T_XP = 8,
  parameter int NB = 8,
  parameter int BEATS_PER_CLK = 2,
  parameter int MRW = 8,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           row_valid,
  input  logic [2:0]     row_op,
  input  logic           row_pc,
  input  logic [BW-1:0]  row_bank,
  input  logic [MRW-1:0] row_arg,
  output logic           row_grant,
  input  logic           col_valid,
  input  logic           col_wr,
  input  logic           col_pc,
  input  logic [BW-1:0]  col_bank,
  output logic           col_grant,
  output logic [1:0]     lane_busy,
  output logic [1:0]     pwr_state,
  output logic [MRW-1:0] mode_reg
);
  localparam int BURST_CYC = 8 / BEATS_PER_CLK;
  localparam int M1 = (T_RRD > T_RCD) ? T_RRD : T_RCD;
  localparam int M2 = (T_RP > T_XP) ? T_RP : T_XP;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M3 > BURST_CYC) ? M3 : BURST_CYC;
  localparam int CW = $clog2(TMAX + 1);

  localparam logic [2:0] OP_ACT = 3'd0, OP_PRE = 3'd1, OP_PDE = 3'd2, OP_PDX = 3'd3,
                         OP_SRE = 3'd4, OP_SRX = 3'd5, OP_MRS = 3'd6;
  localparam logic [1:0] PW_ON = 2'd0, PW_PD = 2'd1, PW_SR = 2'd2;

  logic [CW-1:0] rrd_c [2];
  logic [CW-1:0] rcd_c [2];
  logic [CW-1:0] rp_c  [2];
  logic [CW-1:0] bst_c [2];
  logic [CW-1:0] xp_c;
  logic [NB-1:0] open_q [2];
  logic [1:0]    pwr_q;
  logic [MRW-1:0] mr_q;
  logic          row_ok;

  wire ready = (pwr_q == PW_ON) && (xp_c == '0);
  wire any_open = (|open_q[0]) || (|open_q[1]);
  wire pc_quiet0 = (rrd_c[0] == '0) && (rcd_c[0] == '0) && (rp_c[0] == '0) && (bst_c[0] == '0);
  wire pc_quiet1 = (rrd_c[1] == '0) && (rcd_c[1] == '0) && (rp_c[1] == '0) && (bst_c[1] == '0);
  wire both_quiet = pc_quiet0 && pc_quiet1;
  wire row_open = open_q[row_pc][row_bank];
  wire col_open = open_q[col_pc][col_bank];

  always_comb begin
    row_ok = 1'b0;
    case (row_op)
      OP_ACT: row_ok = ready && !row_open && rrd_c[row_pc] == '0 && rp_c[row_pc] == '0;
      OP_PRE: row_ok = ready && row_open;
      OP_PDE: row_ok = ready && both_quiet;
      OP_SRE: row_ok = ready && both_quiet && !any_open;
      OP_PDX: row_ok = (pwr_q == PW_PD);
      OP_SRX: row_ok = (pwr_q == PW_SR);
      OP_MRS: row_ok = ready && !any_open && rp_c[0] == '0 && rp_c[1] == '0;
      default: row_ok = 1'b0;
    endcase
  end

  assign row_grant = row_valid && row_ok;
  assign col_grant = col_valid && ready && col_open && rcd_c[col_pc] == '0 && bst_c[col_pc] == '0;
  assign lane_busy = {bst_c[1] != '0, bst_c[0] != '0};
  assign pwr_state = pwr_q;
  assign mode_reg = mr_q;

  wire g_act = row_grant && row_op == OP_ACT;
  wire g_pre = row_grant && row_op == OP_PRE;
  wire g_exit = row_grant && (row_op == OP_PDX || row_op == OP_SRX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        rrd_c[p] <= '0;
        rcd_c[p] <= '0;
        rp_c[p] <= '0;
        bst_c[p] <= '0;
        open_q[p] <= '0;
      end
      xp_c <= '0;
      pwr_q <= PW_ON;
      mr_q <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (g_act && row_pc == p[0]) begin
          rrd_c[p] <= CW'(T_RRD - 1);
          rcd_c[p] <= CW'(T_RCD - 1);
          open_q[p] <= open_q[p] | (NB'(1) << row_bank);
        end else begin
          if (rrd_c[p] != '0) rrd_c[p] <= rrd_c[p] - 1'b1;
          if (rcd_c[p] != '0) rcd_c[p] <= rcd_c[p] - 1'b1;
        end
        if (g_pre && row_pc == p[0]) begin
          rp_c[p] <= CW'(T_RP - 1);
          open_q[p] <= open_q[p] & ~(NB'(1) << row_bank);
        end else if (rp_c[p] != '0) begin
          rp_c[p] <= rp_c[p] - 1'b1;
        end
        if (col_grant && col_pc == p[0]) bst_c[p] <= CW'(BURST_CYC - 1);
        else if (bst_c[p] != '0) bst_c[p] <= bst_c[p] - 1'b1;
      end
      if (g_exit) xp_c <= CW'(T_XP - 1);
      else if (xp_c != '0) xp_c <= xp_c - 1'b1;
      if (row_grant) begin
        case (row_op)
          OP_PDE: pwr_q <= PW_PD;
          OP_SRE: pwr_q <= PW_SR;
          OP_PDX, OP_SRX: pwr_q <= PW_ON;
          OP_MRS: mr_q <= row_arg;
          default: ;
        endcase
      end
    end
  end

  // R8
  lowpower_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != PW_ON) |-> !col_grant);

  // R9
  exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (T_XP > 1 && $past(pwr_state) != PW_ON && pwr_state == PW_ON) |-> (!row_grant && !col_grant));

  // R6
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (BURST_CYC > 1 && col_grant) |=> lane_busy[$past(col_pc)]);

  // R7
  sre_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_grant && row_op == OP_SRE) |=> (pwr_state == PW_SR && !any_open));

  // R12
  nop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_op == 3'd7) |-> !row_grant);

  // R4
  pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_grant && row_op == OP_PRE) |=> !open_q[$past(row_pc)][$past(row_bank)]);

  // R10
  mrs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_grant && row_op == OP_MRS) |=> mode_reg == $past(row_arg));

  wire unused_wr = col_wr;
endmodule

// File: tb/tb_pc_cmd_guard.sv
module tb_pc_cmd_guard;
  localparam int T_RRD = 3, T_RCD = 4, T_RP = 5, T_XP = 6, NB = 4, BPC = 2, MRW = 8;
  localparam int BURST = 8 / BPC;

  logic clk = 0;
  logic rst_n = 0;
  logic row_valid = 0, row_pc = 0, row_grant;
  logic [2:0] row_op = 3'd7;
  logic [1:0] row_bank = 0;
  logic [MRW-1:0] row_arg = 0;
  logic col_valid = 0, col_wr = 0, col_pc = 0, col_grant;
  logic [1:0] col_bank = 0;
  logic [1:0] lane_busy, pwr_state;
  logic [MRW-1:0] mode_reg;

  always #4 clk = ~clk;

  pc_cmd_guard #(.T_RRD(T_RRD), .T_RCD(T_RCD), .T_RP(T_RP), .T_XP(T_XP), .NB(NB),
                 .BEATS_PER_CLK(BPC), .MRW(MRW)) dut (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_op(row_op), .row_pc(row_pc),
    .row_bank(row_bank), .row_arg(row_arg), .row_grant(row_grant), .col_valid(col_valid),
    .col_wr(col_wr), .col_pc(col_pc), .col_bank(col_bank), .col_grant(col_grant),
    .lane_busy(lane_busy), .pwr_state(pwr_state), .mode_reg(mode_reg));

  int n_chk = 0, n_bad = 0;
  int tcur = 0;
  int rrd_t[2], rcd_t[2], rp_t[2], bst_t[2], xp_t;
  bit open_m[2][NB];
  int pwr_m;
  int mr_m;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, tcur, act, exp);
    end
  endtask

  function automatic bit any_open_m();
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < NB; b++)
        if (open_m[p][b]) return 1;
    return 0;
  endfunction

  function automatic bit quiet_m(int p);
    return tcur >= rrd_t[p] && tcur >= rcd_t[p] && tcur >= rp_t[p] && tcur >= bst_t[p];
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      rrd_t[p] = 0; rcd_t[p] = 0; rp_t[p] = 0; bst_t[p] = 0;
      for (int b = 0; b < NB; b++) open_m[p][b] = 0;
    end
    xp_t = 0; pwr_m = 0; mr_m = 0;
  endtask

  function automatic string row_tag(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2, 4: return "R7";
      3, 5: return "R8";
      6: return "R10";
      default: return "R12";
    endcase
  endfunction

  // Compare one cycle against the model, then advance the model.
  task automatic step();
    bit rdy, exp_row, exp_col;
    int rp, cp;
    #1;
    rp = row_pc; cp = col_pc;
    rdy = (pwr_m == 0) && (tcur >= xp_t);
    exp_row = 0;
    if (row_valid) begin
      case (row_op)
        3'd0: exp_row = rdy && !open_m[rp][row_bank] && tcur >= rrd_t[rp] && tcur >= rp_t[rp];
        3'd1: exp_row = rdy && open_m[rp][row_bank];
        3'd2: exp_row = rdy && quiet_m(0) && quiet_m(1);
        3'd4: exp_row = rdy && quiet_m(0) && quiet_m(1) && !any_open_m();
        3'd3: exp_row = (pwr_m == 1);
        3'd5: exp_row = (pwr_m == 2);
        3'd6: exp_row = rdy && !any_open_m() && tcur >= rp_t[0] && tcur >= rp_t[1];
        default: exp_row = 0;
      endcase
    end
    exp_col = col_valid && rdy && open_m[cp][col_bank] && tcur >= rcd_t[cp] && tcur >= bst_t[cp];
    chk(row_grant === exp_row, row_tag(row_op), row_grant, exp_row);
    chk(col_grant === exp_col, "R5", col_grant, exp_col);
    chk(lane_busy[0] === (tcur < bst_t[0]), "R6", lane_busy[0], tcur < bst_t[0]);
    chk(lane_busy[1] === (tcur < bst_t[1]), "R6", lane_busy[1], tcur < bst_t[1]);
    chk(pwr_state === pwr_m[1:0], "R8", pwr_state, pwr_m);
    chk(mode_reg === mr_m[MRW-1:0], "R10", mode_reg, mr_m);
    if (exp_row) begin
      case (row_op)
        3'd0: begin rrd_t[rp] = tcur + T_RRD; rcd_t[rp] = tcur + T_RCD; open_m[rp][row_bank] = 1; end
        3'd1: begin rp_t[rp] = tcur + T_RP; open_m[rp][row_bank] = 0; end
        3'd2: pwr_m = 1;
        3'd4: pwr_m = 2;
        3'd3, 3'd5: begin pwr_m = 0; xp_t = tcur + T_XP; end
        3'd6: mr_m = row_arg;
        default: ;
      endcase
    end
    if (exp_col) bst_t[cp] = tcur + BURST;
    @(posedge clk);
    tcur++;
    @(negedge clk);
  endtask

  task automatic drive(input bit rv, input int op, input int rpc, input int rb,
                       input bit cv, input int cpc, input int cb);
    row_valid = rv; row_op = op[2:0]; row_pc = rpc[0]; row_bank = rb[1:0];
    row_arg = row_arg + 8'd37;
    col_valid = cv; col_pc = cpc[0]; col_bank = cb[1:0]; col_wr = ~col_wr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drive(0, 7, 0, 0, 0, 0, 0);
      step();
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk(pwr_state === 2'd0, "R1", pwr_state, 0);
    chk(lane_busy === 2'd0, "R1", lane_busy, 0);
    chk(mode_reg === '0, "R1", mode_reg, 0);
    drive(0, 7, 0, 0, 1, 0, 0);
    #1 chk(col_grant === 1'b0, "R1", col_grant, 0);
    step();

    // R2: activate PC0 then PC1 on consecutive cycles
    drive(1, 0, 0, 0, 0, 0, 0); step();
    drive(1, 0, 1, 0, 0, 0, 0);
    #1 chk(row_grant === 1'b1, "R2", row_grant, 1);
    step();
    // R3: same-PC activate spacing
    drive(1, 0, 0, 1, 0, 0, 0); step();
    drive(1, 0, 0, 1, 0, 0, 0); step();
    idle(T_RCD);
    // R11: row and column granted in the same cycle
    drive(1, 0, 1, 2, 1, 0, 0);
    #1 chk(row_grant === 1'b1 && col_grant === 1'b1, "R11", {row_grant, col_grant}, 3);
    step();
    drive(0, 7, 0, 0, 1, 0, 0); step();  // R6: lane still busy
    idle(BURST);
    // close everything, then self-refresh and exit; R9 window
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < NB; b++) begin
        drive(1, 1, p, b, 0, 0, 0); step();
      end
    idle(T_RP);
    drive(1, 6, 0, 0, 0, 0, 0); step();
    drive(1, 4, 0, 0, 0, 0, 0); step();
    drive(1, 0, 0, 0, 0, 0, 0); step();
    drive(1, 5, 0, 0, 0, 0, 0); step();
    drive(1, 6, 0, 0, 0, 0, 0);
    #1 chk(row_grant === 1'b0, "R9", row_grant, 0);
    step();
    idle(T_XP);

    // biased random traffic
    for (int i = 0; i < 6000; i++) begin
      int r, op;
      r = $urandom_range(0, 99);
      op = (r < 30) ? 0 : (r < 58) ? 1 : (r < 63) ? 2 : (r < 72) ? 3 :
           (r < 77) ? 4 : (r < 86) ? 5 : (r < 94) ? 6 : 7;
      drive($urandom_range(0, 9) < 8, op, $urandom_range(0, 1), $urandom_range(0, NB - 1),
            $urandom_range(0, 9) < 6, $urandom_range(0, 1), $urandom_range(0, NB - 1));
      step();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule